// File: doc/BRIEF.md
# Twelve-Pin GPIO Controller with Latched Level Interrupts

This block drives and samples twelve general-purpose pins through a small word-addressed register port. Software sets an output data vector and a separate output-enable vector, which leave the block as plain signals for a pad ring to use. It reads the pin levels through a two-stage synchronizer.

Each pin can raise a level-sensitive interrupt. Software picks active-high or active-low detection per pin. A pending condition is latched into a status register and cleared by writing ones. An enable register picks which pending bits reach the single combined interrupt output. Because detection is by level, a cleared bit whose source is still active comes back one cycle later. Software should remove the cause first and then acknowledge. One further 32-bit register is plain storage for pin-function selection logic that lies outside this block.

The bus is a one-cycle write strobe with a combinational read. Register `k` sits at byte offset `4*k`, and the port carries the word index `k`.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pin_out`, `pin_oe` and `irq` are 0, all pins are inputs, all interrupts are masked and all polarities are active-high.
- R2: Word 0 (offset 0x00) holds output data and word 1 (0x04) holds output enable. Bit n drives `pin_out[n]` or `pin_oe[n]`. Bits 31:12 read as zero. Both registers keep their value unless they are written.
- R3: Word 2 (0x08) reads the pin levels after two clock edges of synchronization. Writes to it are ignored.
- R4: The polarity of pin n is bit 4*(n mod 8) of word 4 (0x10) for pins 0–7, and of word 6 (0x18) for pins 8–11. A value of 0 selects active-high and 1 selects active-low. All other bits of these words read as zero.
- R5: A status bit (word 3, 0x0C) sets in the cycle after its synchronized pin is at the active level. It stays set after the level goes away, and it latches whether or not the pin is enabled.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: A clear takes priority only in the cycle of the write. If the source is still active, the bit reads 0 for one cycle and is then set again.
- R8: `irq` is the OR over pins of status AND enable. The enable register is word 5 (0x14), and a 0 in it masks the pin.
- R9: Word 7 (0x1C) is a 32-bit read/write register with no effect on any other output or register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_word_addr | input | 3 | Register word index (byte offset / 4) |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Output data vector |
| pin_oe | output | 12 | Output enable vector |
| irq | output | 1 | Combined interrupt |

## Verification
The bench goes after the clear-while-active window. A design that let the clear lose would never show the zero cycle, and one that cleared the source path would stay at zero. It also goes after the scattered polarity bits across the two type words. A wrong bit position or register split inverts detection on the wrong pin or leaks reserved bits on read. Writes of zero to status, writes to the input word and writes to the mux word are checked to change nothing. Masked pins are checked to latch status while keeping `irq` low, which catches a design that gates latching with the enable.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  localparam int WORD_W     = 32;
  localparam int SEL_W      = 3;
  localparam int POL_STRIDE = 4;
  localparam int POL_PER_WD = 8;

  typedef enum logic [SEL_W-1:0] {
    SEL_OUT     = 3'd0,
    SEL_OE      = 3'd1,
    SEL_IN      = 3'd2,
    SEL_STAT    = 3'd3,
    SEL_TYPE_LO = 3'd4,
    SEL_IRQEN   = 3'd5,
    SEL_TYPE_HI = 3'd6,
    SEL_MUX     = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] sync_q, sync_d;

  always_comb begin
    meta_d = async_i;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
  parameter int NPINS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] en_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] stat_o,
  output logic             irq_o
);
  logic [NPINS-1:0] qual;
  logic [NPINS-1:0] stat_q, stat_d;

  always_comb begin
    qual   = lvl_i ^ pol_i;
    stat_d = (stat_q | qual) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);

  assert_stat_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(qual & ~clr_i)) == $past(qual & ~clr_i)));
  assert_stat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));
  assert_stat_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((stat_q & $past(clr_i)) == '0));
endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs
  import gpio_lvl_pkg::*;
#(
  parameter int NPINS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [NPINS-1:0]  lvl_i,
  input  logic [NPINS-1:0]  stat_i,
  output logic [NPINS-1:0]  out_o,
  output logic [NPINS-1:0]  oe_o,
  output logic [NPINS-1:0]  en_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [WORD_W-1:0] rdata
);
  localparam int PAD = WORD_W - NPINS;

  logic [NPINS-1:0]  out_q, out_d, oe_q, oe_d, en_q, en_d, pol_q, pol_d;
  logic [WORD_W-1:0] mux_q, mux_d;
  logic [WORD_W-1:0] type_lo_rd, type_hi_rd;

  always_comb begin
    out_d = (wr_en && sel == SEL_OUT)   ? wdata[NPINS-1:0] : out_q;
    oe_d  = (wr_en && sel == SEL_OE)    ? wdata[NPINS-1:0] : oe_q;
    en_d  = (wr_en && sel == SEL_IRQEN) ? wdata[NPINS-1:0] : en_q;
    mux_d = (wr_en && sel == SEL_MUX)   ? wdata            : mux_q;
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pol
    localparam int       BITPOS = POL_STRIDE * (n % POL_PER_WD);
    localparam reg_sel_e TSEL   = (n < POL_PER_WD) ? SEL_TYPE_LO : SEL_TYPE_HI;
    always_comb pol_d[n] = (wr_en && sel == TSEL) ? wdata[BITPOS] : pol_q[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
      en_q  <= '0;
      pol_q <= '0;
      mux_q <= '0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
      en_q  <= en_d;
      pol_q <= pol_d;
      mux_q <= mux_d;
    end
  end

  always_comb begin
    type_lo_rd = '0;
    type_hi_rd = '0;
    for (int n = 0; n < NPINS; n++) begin
      if (n < POL_PER_WD) type_lo_rd[POL_STRIDE*(n%POL_PER_WD)] = pol_q[n];
      else                type_hi_rd[POL_STRIDE*(n%POL_PER_WD)] = pol_q[n];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_OUT:     rdata = {{PAD{1'b0}}, out_q};
      SEL_OE:      rdata = {{PAD{1'b0}}, oe_q};
      SEL_IN:      rdata = {{PAD{1'b0}}, lvl_i};
      SEL_STAT:    rdata = {{PAD{1'b0}}, stat_i};
      SEL_TYPE_LO: rdata = type_lo_rd;
      SEL_IRQEN:   rdata = {{PAD{1'b0}}, en_q};
      SEL_TYPE_HI: rdata = type_hi_rd;
      SEL_MUX:     rdata = mux_q;
      default:     rdata = '0;
    endcase
  end

  assign out_o = out_q;
  assign oe_o  = oe_q;
  assign en_o  = en_q;
  assign pol_o = pol_q;

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_OUT) |=> $stable(out_q));
  assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_OE) |=> $stable(oe_q));
  assert_mux_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_MUX) |=> $stable(mux_q));
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
  import gpio_lvl_pkg::*;
#(
  parameter int NPINS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  bus_word_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  reg_sel_e         sel;
  logic [NPINS-1:0] lvl, pol, en, stat, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign sel = reg_sel_e'(bus_word_addr);
  assign clr = (bus_we && sel == SEL_STAT) ? bus_wdata[NPINS-1:0] : '0;

  gpio_lvl_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .async_i(pin_in), .sync_o(lvl)
  );

  gpio_lvl_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(bus_we), .sel(sel),
    .wdata(bus_wdata), .lvl_i(lvl), .stat_i(stat),
    .out_o(pin_out), .oe_o(pin_oe), .en_o(en), .pol_o(pol),
    .rdata(bus_rdata)
  );

  gpio_lvl_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n_int), .lvl_i(lvl), .pol_i(pol),
    .en_i(en), .clr_i(clr), .stat_o(stat), .irq_o(irq)
  );

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (en == '0) |-> !irq);
  assert_irq_reset_R1: assert property (@(posedge clk)
    !rst_n_int |-> (!irq && pin_oe == '0));
endmodule

// File: tb/gpio_lvl_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_lvl_ctrl_bench;
  localparam int NP = 12;
  localparam logic [31:0] PMASK = 32'hFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pins = '0, pout, poe;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_lvl_ctrl u_gpio_lvl_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_word_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pins),
    .pin_out(pout), .pin_oe(poe), .irq(irq)
  );

  // reference state, written from the requirements
  logic [NP-1:0] m_out, m_oe, m_en, m_pol, m_s1, m_s2, m_stat;
  logic [31:0]   m_mux;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out <= '0; m_oe <= '0; m_en <= '0; m_pol <= '0;
      m_s1 <= '0; m_s2 <= '0; m_stat <= '0; m_mux <= '0;
    end else begin
      m_s1 <= pins;
      m_s2 <= m_s1;
      if (we && addr == 3'd3) m_stat <= (m_stat | (m_s2 ^ m_pol)) & ~wdata[NP-1:0];
      else                    m_stat <= m_stat | (m_s2 ^ m_pol);
      if (we) begin
        case (addr)
          3'd0: m_out <= wdata[NP-1:0];
          3'd1: m_oe  <= wdata[NP-1:0];
          3'd4: for (int n = 0; n < 8; n++) m_pol[n] <= wdata[4*n];
          3'd5: m_en  <= wdata[NP-1:0];
          3'd6: for (int n = 8; n < NP; n++) m_pol[n] <= wdata[4*(n-8)];
          3'd7: m_mux <= wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      3'd0: r = 32'(m_out);
      3'd1: r = 32'(m_oe);
      3'd2: r = 32'(m_s2);
      3'd3: r = 32'(m_stat);
      3'd4: for (int n = 0; n < 8; n++) r[4*n] = m_pol[n];
      3'd5: r = 32'(m_en);
      3'd6: for (int n = 8; n < NP; n++) r[4*(n-8)] = m_pol[n];
      default: r = m_mux;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic look(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    settle(3); rst_n = 1'b1; settle(4);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      look(3'(a), d); chk("R1 reset read", d, 32'h0);
    end
    chk("R1 pin_out", 32'(pout), 0); chk("R1 pin_oe", 32'(poe), 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 output data / enable
    wr(3'd0, 32'hFFFF_FFFF); look(3'd0, d);
    chk("R2 out read", d, PMASK); chk("R2 pin_out", 32'(pout), PMASK);
    wr(3'd1, 32'h1234_5A5A); look(3'd1, d);
    chk("R2 oe read", d, 32'hA5A); chk("R2 pin_oe", 32'(poe), 32'hA5A);

    // R3 input synchronizer, two edges
    @(negedge clk); pins = 12'h5A3;
    @(negedge clk); look(3'd2, d); chk("R3 one edge", d, 32'h0);
    @(negedge clk); look(3'd2, d); chk("R3 two edges", d, 32'h5A3);
    wr(3'd2, 32'hFFFF_FFFF); look(3'd2, d); chk("R3 write ignored", d, 32'h5A3);

    // clear pending bits raised by active-high default before type change
    wr(3'd4, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF);
    look(3'd4, d); chk("R4 type lo", d, 32'h1111_1111);
    look(3'd6, d); chk("R4 type hi", d, 32'h0000_1111);
    wr(3'd3, PMASK);
    // R7 clear while active-low sources (~0x5A3 = 0xA5C) remain
    @(negedge clk); look(3'd3, d); chk("R4 R5 active-low latch", d, 32'hA5C);
    wr(3'd3, PMASK); look(3'd3, d); chk("R7 zero in write cycle", d, 32'h0);
    @(negedge clk); look(3'd3, d); chk("R7 set again", d, 32'hA5C);

    // R5 latch while masked, R8 masking
    chk("R8 masked irq", 32'(irq), 0);
    wr(3'd5, 32'h0000_0004); chk("R8 enabled irq", 32'(irq), 1);
    wr(3'd5, 32'h0000_0001); chk("R8 enable on idle bit", 32'(irq), 0);

    // R6 write-zero keeps, write-one clears once source gone
    @(negedge clk); pins = 12'hFFF; settle(3);
    look(3'd3, d); chk("R5 hold after source gone", d, 32'hA5C);
    wr(3'd3, 32'h0); look(3'd3, d); chk("R6 write zero keeps", d, 32'hA5C);
    wr(3'd3, 32'h0000_0A00); look(3'd3, d); chk("R6 partial clear", d, 32'h05C);
    wr(3'd3, PMASK); @(negedge clk); look(3'd3, d); chk("R6 stays clear", d, 32'h0);

    // R9 mux storage only
    wr(3'd7, 32'hDEAD_BEEF); look(3'd7, d); chk("R9 mux read", d, 32'hDEAD_BEEF);
    chk("R9 pin_out untouched", 32'(pout), PMASK);
    look(3'd3, d); chk("R9 status untouched", d, 32'h0);

    // random phase against the reference
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) pins = NP'($urandom);
      we    = ($urandom_range(2) == 0);
      wdata = $urandom;
      addr  = 3'($urandom_range(7));
      #1;
      chk("R2 R3 R4 R5 R6 R9 random read", rdata, exp_rd(addr));
      chk("R8 random irq", 32'(irq), 32'(|(m_stat & m_en)));
      chk("R2 random pins", {4'h0, poe, 4'h0, pout}, {4'h0, m_oe, 4'h0, m_out});
    end
    @(negedge clk); we = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule